// File: doc/BRIEF.md
# Station Address ROM Sync Reader

This block fetches a 48-bit station address from a serial-access ROM. The ROM is reached through a single byte port, and every accepted read moves the ROM's internal pointer one byte on. After a start, the block first reads bytes until it sees an eight-byte framing sequence. If it does not find the sequence within a fixed number of reads, it gives up. It then captures the six address bytes and a two-byte stored checksum. It folds the address into a 16-bit end-around checksum and compares that value with the stored one.

A skip input bypasses the framing search, so the address starts at the first read. Two address classes are rejected and stop the read sequence at once: group addresses and addresses whose vendor prefix is zero. Each run ends with a one-cycle done pulse. The address and the verdict then hold until the next start.

Top module: `arom_sync_reader`

## Requirements
- R1: After reset, done_o, valid_o and rd_req_o are low and addr_o is zero.
- R2: The framing sequence is the bytes FF, 00, 55, AA, FF, 00, 55, AA in read order. A byte that does not match the expected element sends the match position back to the first element. That same byte is not compared again against the first element.
- R3: If the framing sequence has not completed after 32 reads, the run ends with done_o and valid_o low. No further read is issued. A sequence that completes on read 32 is accepted.
- R4: With skip_i high at start, the first read is taken as address byte 0 and no search is made.
- R5: Address bytes are read in order. Byte 0 (the first read) appears in addr_o[47:40] and byte 5 in addr_o[7:0]. A successful run issues exactly 8 reads after the framing sequence.
- R6: If address byte 0 has bit 0 set, the run ends immediately after that read with valid_o low.
- R7: If address bytes 0, 1 and 2 are all zero, the run ends immediately after byte 2 with valid_o low.
- R8: The computed checksum is formed from three words: word k = byte(2k) + 256·byte(2k+1). It starts at word 0. For words 1 and 2 it is doubled, reduced by 65535 if above 65535, has the word added, and is reduced by 65535 again.
- R9: The last reduction, after word 2 is added, applies when the sum is greater than or equal to 65535.
- R10: The stored checksum is the two reads after byte 5, low byte first. valid_o is high only when it equals the computed value.
- R11: A byte is consumed only at a rising edge where rd_req_o and rd_ack_i are both high. rd_req_o stays high while the block waits for an acknowledge.
- R12: done_o is high for exactly one cycle per accepted start. A start while a run is in progress is ignored. addr_o and valid_o do not change from the end of a run until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a run when the block is idle |
| skip_i | input | 1 | Sampled with start_i; high bypasses the framing search |
| rd_req_o | output | 1 | Byte read request to the ROM |
| rd_ack_i | input | 1 | ROM acknowledge; the byte is taken when both are high |
| rd_data_i | input | 8 | ROM byte, valid with rd_ack_i |
| addr_o | output | 48 | Captured station address, byte 0 in the top bits |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| valid_o | output | 1 | Verdict of the last run; high when the address passed every check |

## Verification
The assertions take for granted that the ROM drives rd_ack_i and rd_data_i only as the answer to an outstanding request. They also take for granted that start_i is a short pulse, so that a held request really means the block is busy. The bench ROM model raises the acknowledge only while it sees rd_req_o, with an optional stall pattern. Each start is driven for one cycle in the idle window, or deliberately mid-run to show that it is ignored.

// File: rtl/arom_pkg.sv
package arom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_ADDR,
    ST_CSUM
  } rd_state_e;

  // framing sequence repeats with period four
  function automatic logic [7:0] sync_byte(input logic [7:0] pos);
    case (pos[1:0])
      2'd0:    sync_byte = 8'hFF;
      2'd1:    sync_byte = 8'h00;
      2'd2:    sync_byte = 8'h55;
      default: sync_byte = 8'hAA;
    endcase
  endfunction

endpackage

// File: rtl/arom_sync_hunt.sv
module arom_sync_hunt import arom_pkg::*; #(
  parameter int unsigned SYNC_LEN   = 8,
  parameter int unsigned HUNT_LIMIT = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       step_i,
  input  logic [7:0] byte_i,
  output logic       hit_o,
  output logic       exhaust_o
);
  localparam int unsigned PW = $clog2(SYNC_LEN);
  localparam int unsigned CW = $clog2(HUNT_LIMIT);

  logic [PW-1:0] pos_q;
  logic [CW-1:0] cnt_q;
  logic          match;

  assign match     = (byte_i == sync_byte(8'(pos_q)));
  assign hit_o     = step_i && match && (pos_q == PW'(SYNC_LEN - 1));
  assign exhaust_o = step_i && !hit_o && (cnt_q == CW'(HUNT_LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      pos_q <= '0;
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
      pos_q <= match ? pos_q + 1'b1 : '0;  // no recheck of a mismatching byte
    end
  end

  AST_HUNT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exhaust_o |=> !step_i);  // R3

endmodule

// File: rtl/arom_csum_fold.sv
module arom_csum_fold #(
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic [8*ADDR_BYTES-1:0] addr_i,
  output logic [15:0]             sum_o
);
  localparam int unsigned NB    = ADDR_BYTES;
  localparam int unsigned NW    = ADDR_BYTES / 2;
  localparam logic [17:0] MOD   = 18'd65535;

  logic [17:0] acc;

  function automatic logic [15:0] word_at(input logic [8*NB-1:0] a, input int unsigned k);
    word_at = {a[8*(NB-2-2*k) +: 8], a[8*(NB-1-2*k) +: 8]};
  endfunction

  always_comb begin
    acc = {2'b00, word_at(addr_i, 0)};
    for (int unsigned k = 1; k < NW; k++) begin
      acc = acc << 1;
      if (acc > MOD) acc = acc - MOD;
      acc = acc + {2'b00, word_at(addr_i, k)};
      if (k == NW - 1) begin
        if (acc >= MOD) acc = acc - MOD;
      end else begin
        if (acc > MOD) acc = acc - MOD;
      end
    end
    sum_o = acc[15:0];
  end

endmodule

// File: rtl/arom_sync_reader.sv
module arom_sync_reader import arom_pkg::*; #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned SYNC_LEN   = 8,
  parameter int unsigned HUNT_LIMIT = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    skip_i,
  output logic                    rd_req_o,
  input  logic                    rd_ack_i,
  input  logic [7:0]              rd_data_i,
  output logic [8*ADDR_BYTES-1:0] addr_o,
  output logic                    done_o,
  output logic                    valid_o
);
  localparam int unsigned AW  = 8 * ADDR_BYTES;
  localparam int unsigned BCW = $clog2(ADDR_BYTES);

  rd_state_e      st_q;
  logic [BCW-1:0] bcnt_q;
  logic [AW-1:0]  addr_q;
  logic [7:0]     ck_lo_q;
  logic           done_q, valid_q;
  logic           take, launch, hunt_hit, hunt_out;
  logic [15:0]    calc_sum;

  assign rd_req_o = (st_q != ST_IDLE);
  assign take     = rd_req_o && rd_ack_i;
  assign launch   = (st_q == ST_IDLE) && start_i;

  arom_sync_hunt #(.SYNC_LEN(SYNC_LEN), .HUNT_LIMIT(HUNT_LIMIT)) u_hunt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (launch),
    .step_i   (take && (st_q == ST_HUNT)),
    .byte_i   (rd_data_i),
    .hit_o    (hunt_hit),
    .exhaust_o(hunt_out)
  );

  arom_csum_fold #(.ADDR_BYTES(ADDR_BYTES)) u_fold (
    .addr_i(addr_q),
    .sum_o (calc_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      bcnt_q  <= '0;
      addr_q  <= '0;
      ck_lo_q <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          addr_q  <= '0;
          valid_q <= 1'b0;
          bcnt_q  <= '0;
          st_q    <= skip_i ? ST_ADDR : ST_HUNT;
        end
        ST_HUNT: begin
          if (hunt_hit) st_q <= ST_ADDR;
          else if (hunt_out) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        ST_ADDR: if (take) begin
          addr_q <= {addr_q[AW-9:0], rd_data_i};
          bcnt_q <= bcnt_q + 1'b1;
          if ((bcnt_q == '0 && rd_data_i[0]) ||
              (bcnt_q == BCW'(2) && addr_q[15:0] == '0 && rd_data_i == '0)) begin
            st_q   <= ST_IDLE;  // group address or zero vendor prefix
            done_q <= 1'b1;
          end else if (bcnt_q == BCW'(ADDR_BYTES - 1)) begin
            st_q   <= ST_CSUM;
            bcnt_q <= '0;
          end
        end
        ST_CSUM: if (take) begin
          if (bcnt_q == '0) begin
            ck_lo_q <= rd_data_i;
            bcnt_q  <= 1'b1;
          end else begin
            st_q    <= ST_IDLE;
            done_q  <= 1'b1;
            valid_q <= ({rd_data_i, ck_lo_q} == calc_sum);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_o  = addr_q;
  assign done_o  = done_q;
  assign valid_o = valid_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R12
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);  // R11
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_req_o && !start_i) |=> ($stable(addr_o) && $stable(valid_o)));  // R12
  AST_VALID_UNICAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !addr_o[AW-8]);  // R6
  AST_VALID_OUI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (addr_o[AW-1:AW-24] != '0));  // R7

endmodule

// File: tb/sim_arom_sync_reader.sv
module sim_arom_sync_reader;
  localparam int PERIOD = 10;
  localparam int NV = 8;
  // {skip, junk[4:0], bad_ck, addr[47:0]}
  localparam logic [54:0] VECS [NV] = '{
    {1'b0, 5'd0,  1'b0, 48'h08002B123456},
    {1'b0, 5'd3,  1'b0, 48'h0000F8010203},
    {1'b1, 5'd0,  1'b0, 48'hAA0004001234},
    {1'b0, 5'd1,  1'b1, 48'h08002BAABBCC},
    {1'b1, 5'd0,  1'b0, 48'h01005E000001},
    {1'b0, 5'd2,  1'b0, 48'h000000112233},
    {1'b0, 5'd24, 1'b0, 48'h02608C0A0B0C},
    {1'b0, 5'd25, 1'b0, 48'h02608C0A0B0C}
  };

  logic clk_i = 0, rst_ni = 0, start_i = 0, skip_i = 0;
  logic rd_req_o, rd_ack_i = 0, done_o, valid_o;
  logic [7:0] rd_data_i = 0;
  logic [47:0] addr_o;

  logic [7:0] rom [64];
  int ptr = 0, nreads = 0, ndone = 0, nchk = 0, nfail = 0;
  logic req_q = 0, stall_en = 0;
  logic [1:0] tick = 0;

  arom_sync_reader u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .skip_i(skip_i),
    .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .addr_o(addr_o), .done_o(done_o), .valid_o(valid_o)
  );

  always #(PERIOD/2) clk_i = ~clk_i;

  // ROM model: one byte per accepted request, pointer advances on accept
  always @(negedge clk_i) begin
    if (rd_ack_i && req_q) begin
      ptr++;
      nreads++;
    end
    req_q = rd_req_o;
    tick = tick + 1'b1;
    rd_ack_i = req_q && (!stall_en || tick != 2'd0);
    rd_data_i = rom[ptr % 64];
    if (done_o) ndone++;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_ck(input logic [47:0] a);
    int c, w0, w1, w2;
    w0 = {a[39:32], a[47:40]};
    w1 = {a[23:16], a[31:24]};
    w2 = {a[7:0],   a[15:8]};
    c = w0;
    c = c * 2; if (c > 65535) c = c - 65535;
    c = c + w1; if (c > 65535) c = c - 65535;
    c = c * 2; if (c > 65535) c = c - 65535;
    c = c + w2; if (c >= 65535) c = c - 65535;
    return 16'(c);
  endfunction

  task automatic fill_std(input bit skip, input int junk, input logic [47:0] a, input logic [15:0] ck);
    int i = 0;
    for (int k = 0; k < 64; k++) rom[k] = 8'h5A;
    if (!skip) begin
      i = junk;
      for (int k = 0; k < 8; k++) rom[i + k] = (k % 4 == 0) ? 8'hFF : (k % 4 == 1) ? 8'h00 :
                                                (k % 4 == 2) ? 8'h55 : 8'hAA;
      i = i + 8;
    end
    for (int k = 0; k < 6; k++) rom[i + k] = a[47 - 8*k -: 8];
    rom[i + 6] = ck[7:0];
    rom[i + 7] = ck[15:8];
  endtask

  // run one read sequence; poke>0 pulses start again that many cycles in
  task automatic run(input bit skip, input int poke, output bit timed_out);
    int t = 0;
    ptr = 0; nreads = 0; ndone = 0;
    skip_i = skip; start_i = 1;
    @(posedge clk_i); #1 start_i = 0;
    timed_out = 0;
    while (!done_o && t < 3000) begin
      @(posedge clk_i); #1;
      t++;
      start_i = (t == poke);
    end
    start_i = 0;
    if (t >= 3000) timed_out = 1;
  endtask

  task automatic finish_case(input string tag, input bit tmo, input bit ev, input logic [47:0] ea, input int er);
    logic [47:0] a0;
    logic v0;
    check(!tmo, {tag, " R12 done seen"}, tmo, 0);
    v0 = valid_o; a0 = addr_o;
    check(valid_o == ev, {tag, " verdict"}, valid_o, ev);
    if (ev) check(addr_o == ea, {tag, " R5 address"}, addr_o, ea);
    repeat (4) begin @(posedge clk_i); #1; end
    check(nreads == er, {tag, " R11 read count"}, nreads, er);
    check(ndone == 1, {tag, " R12 one done pulse"}, ndone, 1);
    check(valid_o == v0 && addr_o == a0, {tag, " R12 hold"}, {valid_o, addr_o}, {v0, a0});
  endtask

  initial begin
    #(PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    bit tmo, ev, skip, bad, mc, oui0;
    int junk, pre, er;
    string tag;
    logic [47:0] a;
    for (int k = 0; k < 64; k++) rom[k] = 8'h5A;
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    check(done_o == 0 && valid_o == 0 && rd_req_o == 0, "R1 reset flags",
          {done_o, valid_o, rd_req_o}, 0);
    check(addr_o == 0, "R1 reset address", addr_o, 0);
    rst_ni = 1;
    @(posedge clk_i); #1;

    for (int v = 0; v < NV; v++) begin
      skip = VECS[v][54]; junk = int'(VECS[v][53:49]); bad = VECS[v][48]; a = VECS[v][47:0];
      stall_en = v[0];
      fill_std(skip, junk, a, ref_ck(a) ^ (bad ? 16'h0001 : 16'h0000));
      mc = a[40]; oui0 = (a[47:24] == 0);
      pre = skip ? 0 : junk + 8;
      ev = 0;
      if (!skip && junk + 8 > 32) begin er = 32; tag = "R3 limit"; end
      else if (mc) begin er = pre + 1; tag = "R6 group"; end
      else if (oui0) begin er = pre + 3; tag = "R7 zero prefix"; end
      else begin
        er = pre + 8; ev = !bad;
        tag = bad ? "R10 bad stored" : skip ? "R4 skip" : (junk == 24) ? "R3 at limit" : "R8 fold";
      end
      run(skip, 0, tmo);
      finish_case($sformatf("vec%0d %s", v, tag), tmo, ev, a, er);
    end
    stall_en = 0;

    // R2: mismatching FF is not rechecked, so the sequence is missed
    for (int k = 0; k < 64; k++) rom[k] = 8'h5A;
    begin
      logic [7:0] s [11] = '{8'hFF,8'h00,8'h55,8'hFF,8'h00,8'h55,8'hAA,8'hFF,8'h00,8'h55,8'hAA};
      for (int k = 0; k < 11; k++) rom[k] = s[k];
    end
    for (int k = 0; k < 6; k++) rom[11 + k] = 8'h08 + 8'(k);
    run(0, 0, tmo);
    finish_case("R2 no recheck", tmo, 0, 0, 32);

    // R2: mismatch resets, a following FF restarts the match
    a = 48'h08002B123456;
    fill_std(0, 4, a, ref_ck(a));
    rom[0] = 8'hFF; rom[1] = 8'h00; rom[2] = 8'h55; rom[3] = 8'hFF;
    run(0, 0, tmo);
    finish_case("R2 restart", tmo, 1, a, 20);

    // R9: sum equals 65535 before the last reduction; folds to 0000
    a = 48'h02000000F7FF;
    fill_std(1, 0, a, 16'h0000);
    run(1, 0, tmo);
    finish_case("R9 reduce at equal", tmo, 1, a, 8);
    fill_std(1, 0, a, 16'hFFFF);
    run(1, 0, tmo);
    finish_case("R9 unreduced rejected", tmo, 0, a, 8);

    // R10: low byte first; swapped stored bytes must be rejected
    a = 48'h08002B123456;
    fill_std(1, 0, a, {ref_ck(a)[7:0], ref_ck(a)[15:8]});
    run(1, 0, tmo);
    finish_case("R10 byte order", tmo, (ref_ck(a)[7:0] == ref_ck(a)[15:8]), a, 8);

    // R12: start mid-run is ignored
    fill_std(0, 0, a, ref_ck(a));
    stall_en = 1;
    run(0, 5, tmo);
    finish_case("R12 start while busy", tmo, 1, a, 16);
    stall_en = 0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule